// File: doc/BRIEF.md
# Block Cipher Data Register Bank

This block is the bus-side storage that surrounds a 128-bit block cipher engine. It keeps a four-word key, a four-word text register and a four-word auxiliary buffer, each word 32 bits wide. A simple word-addressed register bus reaches all of them. Some alias addresses change how the text is reached: one set of aliases XORs written data into the text words in place, and another returns text XOR buffer when read. A small IDLE/BUSY controller stands in for the cipher engine. It issues a one-cycle start pulse, shows the selected block and the key on plain output pins, and accepts a done strobe together with a 128-bit result, which is then written into the text register.

An operation can be launched in two ways. Software can write an operation code to the trigger register. The bank can also launch one by itself when selected accesses hit word 3, if those auto-trigger events are enabled. Both kinds of launch are refused until all four key words have been written. Clear requests act only while the engine is idle. An abort works in any state and returns the bank to a clean state.

The bus has no back-pressure. Every cycle with `bus_req` high is one complete access. A write takes effect at the clock edge that ends that cycle. Read data is returned combinationally in the same cycle.

Top module: `blkreg_bank`

## Requirements
- R1: After reset the state is idle, the key is not valid, and the text, buffer and auto-trigger configuration all read as zero.
- R2: The text, buffer and key words are placed as follows: word n sits at address base+n and holds bits 32n+31:32n of the 128-bit value. The text base is 12, the buffer base is 20 and the key base is 8. The text appears on `core_block` when the selected source is text.
- R3: A write to XOR-alias word n (address 16+n) sets text word n to its previous value XOR the written data.
- R4: A read of address 24+n returns text word n XOR buffer word n. The read changes no state.
- R5: A write to address 0 with bits 1:0 equal to 1 launches an operation on the text. A value of 2 launches an operation on the buffer. The values 0 and 3 are ignored, and any launch is ignored while busy. A launch sets busy and raises `core_start` for exactly one cycle.
- R6: Key words are write-only and read as zero. The key becomes valid once all four words have been written since reset. Before that, every launch is refused.
- R7: The status register at address 3 reads busy in bit 0, key valid in bit 1, and in bits 3:2 the initiator ID of the last key write.
- R8: A write to address 1 clears the buffer when bit 0 is set and the text when bit 1 is set. A clear while busy has no effect.
- R9: A write to address 2 with bit 0 set aborts the operation. Busy drops, and the text, buffer and auto-trigger configuration become zero.
- R10: The auto-trigger configuration at address 4 has four enable bits. Bit 0 enables a launch on a write to text word 3. Bit 1 enables a launch on a read of text word 3. Bit 2 enables a launch on a write to XOR word 3. Bit 3 enables a launch on a write to buffer word 3. An auto launch always operates on the text.
- R11: While busy, bus writes to the text, the XOR aliases and the buffer are dropped. A done strobe while busy loads `core_result` into the text and returns the state to idle.
- R12: The key persists across operations, so a new operation can be launched without rewriting it.
- R13: When an abort and a done strobe arrive in the same cycle, the abort wins: the text becomes zero and the result is discarded.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_req | input | 1 | Access strobe; one access per cycle |
| bus_we | input | 1 | 1 for a write, 0 for a read |
| bus_addr | input | 5 | Word address |
| bus_wdata | input | 32 | Write data |
| bus_initiator | input | 2 | ID of the initiator making the access |
| bus_rdata | output | 32 | Read data, valid in the same cycle as the access |
| core_start | output | 1 | One-cycle pulse when an operation begins |
| core_key | output | 128 | Stored key |
| core_block | output | 128 | Text or buffer, depending on the launched source |
| core_done | input | 1 | Engine done strobe |
| core_result | input | 128 | Engine result, loaded into the text on done |
| busy | output | 1 | The engine owns the text register |

## Verification
An abort written on the bus and a done strobe from the engine can land in the same cycle. In that case the abort must win, so the result is discarded and the text is zeroed. The bench provokes this by driving the abort write and the done strobe with its result in one cycle. It then reads the text words and the status to confirm that they are zero and idle. Because a launch and a read of text word 3 can also coincide, the bench checks that the read still returns the value the text held before the operation starts.

// File: rtl/blkreg_pkg.sv
package blkreg_pkg;
  typedef enum logic [2:0] {
    GRP_CTRL = 3'd0,
    GRP_CFG  = 3'd1,
    GRP_KEY  = 3'd2,
    GRP_TXT  = 3'd3,
    GRP_TXX  = 3'd4,
    GRP_BUF  = 3'd5,
    GRP_TXB  = 3'd6,
    GRP_NONE = 3'd7
  } grp_e;

  typedef enum logic {ST_IDLE = 1'b0, ST_BUSY = 1'b1} st_e;

  localparam int GRP_W     = 3;
  localparam int CI_TRIG   = 0;
  localparam int CI_CLEAR  = 1;
  localparam int CI_ABORT  = 2;
  localparam int CI_STATUS = 3;

  localparam logic [1:0] OP_TEXT = 2'd1;
  localparam logic [1:0] OP_BUF  = 2'd2;

  localparam int AT_WR_TXT = 0;
  localparam int AT_RD_TXT = 1;
  localparam int AT_WR_TXX = 2;
  localparam int AT_WR_BUF = 3;
  localparam int AT_BITS   = 4;
endpackage

// File: rtl/blkreg_words.sv
module blkreg_words #(
  parameter int W  = 32,
  parameter int N  = 4,
  localparam int IW = $clog2(N)
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           clr,
  input  logic           load_en,
  input  logic [N*W-1:0] load_val,
  input  logic           wr_en,
  input  logic [IW-1:0]  wr_idx,
  input  logic           wr_xor,
  input  logic [W-1:0]   wr_data,
  output logic [N*W-1:0] q
);
  for (genvar g = 0; g < N; g++) begin : g_word
    logic [W-1:0] r;
    always_ff @(posedge clk) begin
      if (!rst_n)                          r <= '0;
      else if (clr)                        r <= '0;
      else if (load_en)                    r <= load_val[g*W +: W];
      else if (wr_en && wr_idx == IW'(g))  r <= wr_xor ? (r ^ wr_data) : wr_data;
    end
    assign q[g*W +: W] = r;
  end
endmodule

// File: rtl/blkreg_key.sv
module blkreg_key #(
  parameter int W   = 32,
  parameter int N   = 4,
  parameter int IDW = 2,
  localparam int IW = $clog2(N)
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           wr_en,
  input  logic [IW-1:0]  wr_idx,
  input  logic [W-1:0]   wr_data,
  input  logic [IDW-1:0] wr_id,
  output logic [N*W-1:0] key,
  output logic           valid,
  output logic [IDW-1:0] last_id
);
  logic [N-1:0] seen;
  logic [N-1:0] seen_nxt;

  assign seen_nxt = seen | (N'(1) << wr_idx);

  blkreg_words #(.W(W), .N(N)) u_store (
    .clk(clk), .rst_n(rst_n), .clr(1'b0), .load_en(1'b0), .load_val('0),
    .wr_en(wr_en), .wr_idx(wr_idx), .wr_xor(1'b0), .wr_data(wr_data), .q(key)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      seen    <= '0;
      valid   <= 1'b0;
      last_id <= '0;
    end else if (wr_en) begin
      last_id <= wr_id;
      if (&seen_nxt) begin
        valid <= 1'b1;
        seen  <= '0;
      end else begin
        seen  <= seen_nxt;
      end
    end
  end
endmodule

// File: rtl/blkreg_ctrl.sv
module blkreg_ctrl
  import blkreg_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic launch_req,
  input  logic launch_buf,
  input  logic abort,
  input  logic done_in,
  output logic busy,
  output logic start,
  output logic src_buf,
  output logic finish
);
  st_e st;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st      <= ST_IDLE;
      start   <= 1'b0;
      src_buf <= 1'b0;
    end else begin
      start <= 1'b0;
      if (abort) begin
        st <= ST_IDLE;
      end else if (st == ST_IDLE && launch_req) begin
        st      <= ST_BUSY;
        start   <= 1'b1;
        src_buf <= launch_buf;
      end else if (st == ST_BUSY && done_in) begin
        st <= ST_IDLE;
      end
    end
  end

  assign busy   = (st == ST_BUSY);
  assign finish = busy && done_in && !abort;
endmodule

// File: rtl/blkreg_bank.sv
module blkreg_bank
  import blkreg_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int WORDS  = 4,
  parameter int IDW    = 2,
  localparam int IW     = $clog2(WORDS),
  localparam int ADDR_W = GRP_W + IW,
  localparam int BLK_W  = DATA_W * WORDS
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_req,
  input  logic              bus_we,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  input  logic [IDW-1:0]    bus_initiator,
  output logic [DATA_W-1:0] bus_rdata,
  output logic              core_start,
  output logic [BLK_W-1:0]  core_key,
  output logic [BLK_W-1:0]  core_block,
  input  logic              core_done,
  input  logic [BLK_W-1:0]  core_result,
  output logic              busy
);
  localparam logic [IW-1:0] LAST = IW'(WORDS - 1);

  grp_e              grp;
  logic [IW-1:0]     idx;
  logic              wr, rd, idle, key_valid, src_buf, finish;
  logic [IDW-1:0]    key_id;
  logic [BLK_W-1:0]  txt_q, buf_q;
  logic [AT_BITS-1:0] at_cfg;
  logic              abort_w, clr_txt, clr_buf, manual, manual_buf, auto_hit, launch;
  logic              txt_we, buf_we;

  assign grp  = grp_e'(bus_addr[ADDR_W-1 -: GRP_W]);
  assign idx  = bus_addr[IW-1:0];
  assign wr   = bus_req && bus_we;
  assign rd   = bus_req && !bus_we;
  assign idle = !busy;

  assign abort_w    = wr && grp == GRP_CTRL && idx == IW'(CI_ABORT) && bus_wdata[0];
  assign clr_txt    = abort_w || (wr && idle && grp == GRP_CTRL && idx == IW'(CI_CLEAR) && bus_wdata[1]);
  assign clr_buf    = abort_w || (wr && idle && grp == GRP_CTRL && idx == IW'(CI_CLEAR) && bus_wdata[0]);
  assign manual     = wr && grp == GRP_CTRL && idx == IW'(CI_TRIG) &&
                      (bus_wdata[1:0] == OP_TEXT || bus_wdata[1:0] == OP_BUF);
  assign manual_buf = manual && bus_wdata[1:0] == OP_BUF;
  assign auto_hit   = idx == LAST && (
                        (wr && grp == GRP_TXT && at_cfg[AT_WR_TXT]) ||
                        (rd && grp == GRP_TXT && at_cfg[AT_RD_TXT]) ||
                        (wr && grp == GRP_TXX && at_cfg[AT_WR_TXX]) ||
                        (wr && grp == GRP_BUF && at_cfg[AT_WR_BUF]));
  assign launch     = (manual || auto_hit) && key_valid;
  assign txt_we     = wr && idle && (grp == GRP_TXT || grp == GRP_TXX);
  assign buf_we     = wr && idle && grp == GRP_BUF;

  always_ff @(posedge clk) begin
    if (!rst_n)                                     at_cfg <= '0;
    else if (abort_w)                               at_cfg <= '0;
    else if (wr && grp == GRP_CFG && idx == '0)     at_cfg <= bus_wdata[AT_BITS-1:0];
  end

  blkreg_ctrl u_ctrl (
    .clk(clk), .rst_n(rst_n), .launch_req(launch), .launch_buf(manual_buf),
    .abort(abort_w), .done_in(core_done), .busy(busy), .start(core_start),
    .src_buf(src_buf), .finish(finish)
  );

  blkreg_words #(.W(DATA_W), .N(WORDS)) u_txt (
    .clk(clk), .rst_n(rst_n), .clr(clr_txt), .load_en(finish), .load_val(core_result),
    .wr_en(txt_we), .wr_idx(idx), .wr_xor(grp == GRP_TXX), .wr_data(bus_wdata), .q(txt_q)
  );

  blkreg_words #(.W(DATA_W), .N(WORDS)) u_buf (
    .clk(clk), .rst_n(rst_n), .clr(clr_buf), .load_en(1'b0), .load_val('0),
    .wr_en(buf_we), .wr_idx(idx), .wr_xor(1'b0), .wr_data(bus_wdata), .q(buf_q)
  );

  blkreg_key #(.W(DATA_W), .N(WORDS), .IDW(IDW)) u_key (
    .clk(clk), .rst_n(rst_n), .wr_en(wr && grp == GRP_KEY), .wr_idx(idx),
    .wr_data(bus_wdata), .wr_id(bus_initiator), .key(core_key),
    .valid(key_valid), .last_id(key_id)
  );

  assign core_block = src_buf ? buf_q : txt_q;

  always_comb begin
    bus_rdata = '0;
    unique case (grp)
      GRP_CTRL: if (idx == IW'(CI_STATUS)) begin
        bus_rdata[0]       = busy;
        bus_rdata[1]       = key_valid;
        bus_rdata[2 +: IDW] = key_id;
      end
      GRP_CFG:  if (idx == '0) bus_rdata[AT_BITS-1:0] = at_cfg;
      GRP_TXT:  bus_rdata = txt_q[idx*DATA_W +: DATA_W];
      GRP_BUF:  bus_rdata = buf_q[idx*DATA_W +: DATA_W];
      GRP_TXB:  bus_rdata = txt_q[idx*DATA_W +: DATA_W] ^ buf_q[idx*DATA_W +: DATA_W];
      default:  bus_rdata = '0;
    endcase
  end
endmodule

// File: rtl/blkreg_chk.sv
module blkreg_chk #(
  parameter int DATA_W = 32,
  parameter int WORDS  = 4,
  localparam int IW     = $clog2(WORDS),
  localparam int ADDR_W = 3 + IW,
  localparam int BLK_W  = DATA_W * WORDS
) (
  input logic              clk,
  input logic              rst_n,
  input logic              bus_req,
  input logic              bus_we,
  input logic [ADDR_W-1:0] bus_addr,
  input logic [DATA_W-1:0] bus_wdata,
  input logic              busy,
  input logic              core_start,
  input logic              core_done,
  input logic [BLK_W-1:0]  core_result,
  input logic [BLK_W-1:0]  txt_q,
  input logic [BLK_W-1:0]  buf_q,
  input logic              key_valid
);
  logic [2:0]        g;
  logic [IW-1:0]     i;
  logic              abort_seen, xor_wr, data_wr;
  logic              xor_pend;
  logic [IW-1:0]     xor_idx;
  logic [DATA_W-1:0] xor_exp;

  assign g          = bus_addr[ADDR_W-1 -: 3];
  assign i          = bus_addr[IW-1:0];
  assign abort_seen = bus_req && bus_we && g == 3'd0 && i == IW'(2) && bus_wdata[0];
  assign xor_wr     = bus_req && bus_we && g == 3'd4 && !busy;
  assign data_wr    = bus_req && bus_we && (g == 3'd3 || g == 3'd4 || g == 3'd5);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      xor_pend <= 1'b0;
      xor_idx  <= '0;
      xor_exp  <= '0;
    end else begin
      xor_pend <= xor_wr;
      xor_idx  <= i;
      xor_exp  <= txt_q[i*DATA_W +: DATA_W] ^ bus_wdata;
    end
  end

  // R3
  xor_alias_chk: assert property (@(posedge clk) disable iff (!rst_n)
    xor_pend |-> txt_q[xor_idx*DATA_W +: DATA_W] == xor_exp);

  // R11
  busy_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (data_wr && busy && !core_done) |=> ($stable(txt_q) && $stable(buf_q)));

  // R11
  done_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && core_done && !abort_seen) |=> (!busy && txt_q == $past(core_result)));

  // R9
  abort_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    abort_seen |=> (!busy && txt_q == '0 && buf_q == '0));

  // R6
  key_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> $past(key_valid));

  // R5
  start_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    core_start |-> (busy && $rose(busy)));

  // R5
  start_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    core_start |=> !core_start);
endmodule

bind blkreg_bank blkreg_chk #(.DATA_W(DATA_W), .WORDS(WORDS)) u_chk (
  .clk(clk), .rst_n(rst_n), .bus_req(bus_req), .bus_we(bus_we), .bus_addr(bus_addr),
  .bus_wdata(bus_wdata), .busy(busy), .core_start(core_start), .core_done(core_done),
  .core_result(core_result), .txt_q(txt_q), .buf_q(buf_q), .key_valid(key_valid)
);

// File: tb/sim_blkreg_bank.sv
`timescale 1ns/1ps
module sim_blkreg_bank;
  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         bus_req = 1'b0, bus_we = 1'b0;
  logic [4:0]   bus_addr = '0;
  logic [31:0]  bus_wdata = '0;
  logic [1:0]   bus_initiator = '0;
  logic [31:0]  bus_rdata;
  logic         core_start, core_done = 1'b0, busy;
  logic [127:0] core_key, core_block, core_result = '0;

  int checks = 0, errors = 0;
  logic [31:0] exp_q[$];
  string       tag_q[$];

  localparam logic [4:0] A_TRIG = 0, A_CLR = 1, A_ABORT = 2, A_STAT = 3, A_CFG = 4;
  localparam logic [4:0] A_KEY = 8, A_TXT = 12, A_TXX = 16, A_BUF = 20, A_TXB = 24;

  localparam logic [31:0] T0 = 32'h1111_0000, T1 = 32'h2222_1111, T2 = 32'h3333_2222, T3 = 32'h4444_3333;
  localparam logic [31:0] B0 = 32'h0F0F_0F0F, B1 = 32'h00FF_00FF, B2 = 32'hAAAA_5555, B3 = 32'h1234_5678;
  localparam logic [127:0] RES1 = {32'hCAFE_0003, 32'hCAFE_0002, 32'hCAFE_0001, 32'hCAFE_0000};
  localparam logic [127:0] RES2 = {32'hBEEF_0003, 32'hBEEF_0002, 32'hBEEF_0001, 32'hBEEF_0000};
  localparam logic [127:0] RES3 = {32'h7777_0003, 32'h7777_0002, 32'h7777_0001, 32'h7777_0000};

  always #2.5 clk = ~clk;

  blkreg_bank u0 (
    .clk(clk), .rst_n(rst_n), .bus_req(bus_req), .bus_we(bus_we), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_initiator(bus_initiator), .bus_rdata(bus_rdata),
    .core_start(core_start), .core_key(core_key), .core_block(core_block),
    .core_done(core_done), .core_result(core_result), .busy(busy)
  );

  task automatic chk(input logic [127:0] got, input logic [127:0] exp, input string tag);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s: got %h expected %h", tag, got, exp);
    end
  endtask

  task automatic wr(input logic [4:0] a, input logic [31:0] d, input logic [1:0] id = 2'd0);
    @(posedge clk); #1;
    bus_req = 1'b1; bus_we = 1'b1; bus_addr = a; bus_wdata = d; bus_initiator = id;
    @(posedge clk); #1;
    bus_req = 1'b0; bus_we = 1'b0;
  endtask

  task automatic rd(input logic [4:0] a, input logic [31:0] exp, input string tag);
    exp_q.push_back(exp);
    tag_q.push_back(tag);
    @(posedge clk); #1;
    bus_req = 1'b1; bus_we = 1'b0; bus_addr = a;
    @(posedge clk); #1;
    bus_req = 1'b0;
  endtask

  task automatic done(input logic [127:0] r);
    @(posedge clk); #1;
    core_done = 1'b1; core_result = r;
    @(posedge clk); #1;
    core_done = 1'b0;
  endtask

  // Monitor: compares every read against the scoreboard queue.
  always @(negedge clk) begin
    if (rst_n && bus_req && !bus_we) begin
      if (exp_q.size() == 0) begin
        checks++; errors++;
        $display("FAIL scoreboard: unexpected read got %h expected none", bus_rdata);
      end else begin
        logic [31:0] e;
        string t;
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        chk({96'd0, bus_rdata}, {96'd0, e}, t);
      end
    end
  end

  initial begin
    #(200000 * 5);
    checks++; errors++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    // R1 reset state
    rd(A_STAT, 32'h0, "R1 status");
    rd(A_TXT + 0, 32'h0, "R1 text0");
    rd(A_BUF + 3, 32'h0, "R1 buf3");
    rd(A_CFG, 32'h0, "R1 cfg");
    // R6 refused without key
    wr(A_TRIG, 32'h1);
    rd(A_STAT, 32'h0, "R6 launch refused without key");
    wr(A_KEY + 0, 32'hA0A0_0000, 2'd2);
    wr(A_KEY + 1, 32'hA1A1_0001, 2'd2);
    wr(A_KEY + 2, 32'hA2A2_0002, 2'd2);
    rd(A_STAT, 32'h8, "R7 id=2 key not yet valid");
    wr(A_KEY + 3, 32'hA3A3_0003, 2'd1);
    rd(A_STAT, 32'h6, "R7 id=1 key valid");
    rd(A_KEY + 1, 32'h0, "R6 key reads zero");
    chk(core_key, {32'hA3A3_0003, 32'hA2A2_0002, 32'hA1A1_0001, 32'hA0A0_0000}, "R6 key value");
    // R2 layout
    wr(A_TXT + 0, T0); wr(A_TXT + 1, T1); wr(A_TXT + 2, T2); wr(A_TXT + 3, T3);
    chk(core_block, {T3, T2, T1, T0}, "R2 text word order");
    // R3 xor alias
    wr(A_TXX + 1, 32'hFFFF_0000);
    rd(A_TXT + 1, T1 ^ 32'hFFFF_0000, "R3 xor into text1");
    // R4 text xor buffer read
    wr(A_BUF + 0, B0); wr(A_BUF + 1, B1); wr(A_BUF + 2, B2); wr(A_BUF + 3, B3);
    rd(A_TXB + 2, T2 ^ B2, "R4 text2^buf2");
    rd(A_TXT + 2, T2, "R4 text2 untouched");
    rd(A_BUF + 2, B2, "R4 buf2 untouched");
    // R8 clear buffer when idle
    wr(A_CLR, 32'h1);
    rd(A_BUF + 0, 32'h0, "R8 buf0 cleared");
    rd(A_BUF + 3, 32'h0, "R8 buf3 cleared");
    rd(A_TXT + 0, T0, "R8 text kept");
    wr(A_BUF + 0, B0); wr(A_BUF + 1, B1); wr(A_BUF + 2, B2); wr(A_BUF + 3, B3);
    // R5 invalid codes
    wr(A_TRIG, 32'h0);
    rd(A_STAT, 32'h6, "R5 code 0 ignored");
    wr(A_TRIG, 32'h3);
    rd(A_STAT, 32'h6, "R5 code 3 ignored");
    wr(A_TRIG, 32'h1);
    chk({127'd0, core_start}, 128'd1, "R5 start pulse");
    rd(A_STAT, 32'h7, "R5 busy after text launch");
    // R11 / R8 while busy
    wr(A_TXT + 0, 32'hDEAD_DEAD);
    rd(A_TXT + 0, T0, "R11 text write dropped");
    wr(A_CLR, 32'h2);
    rd(A_TXT + 3, T3, "R8 clear ignored while busy");
    wr(A_BUF + 0, 32'hBEEF_BEEF);
    rd(A_BUF + 0, B0, "R11 buf write dropped");
    wr(A_TRIG, 32'h2);
    done(RES1);
    rd(A_TXT + 0, RES1[31:0], "R11 result word0");
    rd(A_TXT + 3, RES1[127:96], "R11 result word3");
    rd(A_STAT, 32'h6, "R11 idle after done");
    // R12 key persists, R5 buffer source
    wr(A_TRIG, 32'h2);
    rd(A_STAT, 32'h7, "R12 launch without key reload");
    chk(core_block, {B3, B2, B1, B0}, "R5 buffer source");
    done(RES2);
    rd(A_TXT + 2, RES2[95:64], "R11 result2 word2");
    // R10 auto triggers
    wr(A_CFG, 32'hF);
    rd(A_CFG, 32'hF, "R10 cfg readback");
    wr(A_TXT + 3, 32'h55);
    rd(A_STAT, 32'h7, "R10 write text3 launches");
    done(RES3);
    rd(A_TXT + 3, RES3[127:96], "R10 read text3 value");
    rd(A_STAT, 32'h7, "R10 read text3 launches");
    done(RES1);
    wr(A_TXX + 3, 32'h1);
    rd(A_STAT, 32'h7, "R10 xor word3 launches");
    done(RES2);
    wr(A_BUF + 3, 32'h99);
    rd(A_STAT, 32'h7, "R10 buf3 launches");
    // R9 abort
    wr(A_ABORT, 32'h1);
    rd(A_STAT, 32'h6, "R9 idle after abort");
    rd(A_TXT + 0, 32'h0, "R9 text cleared");
    rd(A_BUF + 1, 32'h0, "R9 buf cleared");
    rd(A_CFG, 32'h0, "R9 cfg cleared");
    // R10 with triggers disabled
    wr(A_TXT + 3, 32'h77);
    rd(A_STAT, 32'h6, "R10 no launch when disabled");
    rd(A_TXT + 3, 32'h77, "R10 text3 written");
    // R13 abort and done together
    wr(A_TRIG, 32'h1);
    rd(A_STAT, 32'h7, "R13 busy before race");
    @(posedge clk); #1;
    bus_req = 1'b1; bus_we = 1'b1; bus_addr = A_ABORT; bus_wdata = 32'h1;
    core_done = 1'b1; core_result = RES1;
    @(posedge clk); #1;
    bus_req = 1'b0; bus_we = 1'b0; core_done = 1'b0;
    rd(A_TXT + 1, 32'h0, "R13 abort beats done");
    rd(A_STAT, 32'h6, "R13 idle");
    repeat (3) @(posedge clk);
    if (exp_q.size() != 0) begin
      checks++; errors++;
      $display("FAIL scoreboard: got %0d pending expected 0", exp_q.size());
    end
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule